// File: doc/BRIEF.md
# Key-Protected Sequencer Configuration Bank

This block is the byte-wide configuration bank that sits in front of a power sequencer. A host writes and reads it over a simple single-cycle address/data bus. The bank holds a 256-byte script memory. The sequencer reads that memory through its own read port. The bank also holds the start-slot pointers that tell the sequencer where each event's script begins, one event register per processor group, and a transition configuration register.

Everything that shapes sequencer behaviour is guarded. A write to a guarded register only takes effect once the host has written a two-byte unlock key to the key register. While the bank is locked, a guarded write is dropped and a sticky error flag is raised. The host fills script memory indirectly: it first writes a byte address to the memory-pointer register, then writes the byte to the memory-data register. The pointer does not advance on its own.

Register map, with byte addresses:

| Address | Register | Guarded | Reset value | Access notes |
|---|---|---|---|---|
| 0x00 | key | no | – | reads back the unlock state in bit 0 |
| 0x01 | status | no | – | bit 0 is the error flag; writing 1 to bit 0 clears it |
| 0x02 | memory pointer | yes | – | – |
| 0x03 | memory data | yes | – | – |
| 0x04–0x07 | start slots 0..3 | yes | – | – |
| 0x08–0x0A | group event registers 0..2 | yes | – | – |
| 0x0B | transition configuration | yes | – | – |

Unmapped addresses read as zero, and writes to them are dropped.

Top module: `pwrseq_cfg_bank`

## Requirements
- R1: After reset the bank is locked and the error flag is clear. All start slots read 0x3F (the end marker), the group event registers read 0x00, the transition configuration reads 0x02, and the memory pointer reads 0x00.
- R2: A write of 0xC0 to the key register (0x00), followed by a write of 0x0C, unlocks the bank. Bit 0 of a key-register read and `unlocked_o` then read 1. No other value written after 0xC0 unlocks it.
- R3: A key write that breaks the exact 0xC0-then-0x0C order returns the key logic to locked-idle. Examples are any value other than 0xC0 or 0x0C, or 0x0C not directly preceded by 0xC0. A later 0x0C alone does not unlock.
- R4: Writing 0x00 to the key register while the bank is unlocked locks it again. Guarded writes are then refused.
- R5: A write to a guarded address (0x02 to 0x0B) while the bank is locked changes no register or memory byte, and sets the sticky error flag (status bit 0, `err_o`).
- R6: Writing a byte with bit 0 set to the status register (0x01) clears the error flag. Writing a byte with bit 0 clear leaves the flag unchanged.
- R7: A byte written to memory data (0x03) is stored at the memory-pointer address. It is visible on the sequencer read port and on a host read of 0x03 from the next cycle.
- R8: The memory pointer does not auto-increment. Consecutive data writes overwrite the same byte, the last one wins, and the neighbouring byte is untouched.
- R9: Group event registers (0x08 to 0x0A) read back the last value written. A read-modify-write that sets bit 4 keeps every other bit.
- R10: The transition configuration register (0x0B) resets to 0x02. The host can clear bit 1 by writing the register back with that bit cleared.
- R11: Start slots (0x04 to 0x07) take any written value while the bank is unlocked. Each slot drives byte i of `slot_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| addr | input | 8 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for `addr` (combinational) |
| seq_raddr | input | 8 | Sequencer script-memory read address |
| seq_rdata | output | 8 | Sequencer script-memory read data (combinational) |
| slot_o | output | 32 | Start slots, slot i in byte i |
| grp_evt_o | output | 24 | Group event registers, group i in byte i |
| trans_cfg_o | output | 8 | Transition configuration register |
| unlocked_o | output | 1 | Bank is unlocked |
| err_o | output | 1 | Sticky locked-write error flag |

## Verification
The hardest situation to reach from the ports is the middle state of the key logic, after 0xC0 and before the next key write. Only the second value decides whether the bank opens, and the outputs show nothing until then. The bench reaches this state by pairing 0xC0 with every one of the 256 possible second values and checking the unlock state after each pair. It also runs broken orders and a 0x0C with no preceding 0xC0. The script memory is swept in full through the indirect pointer/data pair and read back on both read paths.

// File: rtl/pwrseq_cfg_pkg.sv
package pwrseq_cfg_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'hC0;
  localparam logic [7:0] KEY_SECOND = 8'h0C;
  localparam logic [7:0] KEY_RELOCK = 8'h00;

  localparam logic [7:0] A_KEY     = 8'h00;
  localparam logic [7:0] A_STATUS  = 8'h01;
  localparam logic [7:0] A_MEMPTR  = 8'h02;
  localparam logic [7:0] A_MEMDATA = 8'h03;
  localparam logic [7:0] A_SLOT0   = 8'h04;

  localparam logic [7:0] SLOT_RST  = 8'h3F;
  localparam logic [7:0] TRANS_RST = 8'h02;

  typedef enum logic [1:0] {
    K_LOCKED = 2'd0,
    K_HALF   = 2'd1,
    K_OPEN   = 2'd2
  } key_state_t;
endpackage

// File: rtl/pwrseq_key_guard.sv
module pwrseq_key_guard
  import pwrseq_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_val,
  output logic       unlocked_o
);
  key_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    if (key_we) begin
      if (key_val == KEY_FIRST)                      st_nx = K_HALF;
      else if (st == K_HALF && key_val == KEY_SECOND) st_nx = K_OPEN;
      else                                            st_nx = K_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= K_LOCKED;
    else        st <= st_nx;
  end

  assign unlocked_o = (st == K_OPEN);

  // R2
  open_after_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_o) |-> $past(st == K_HALF));
  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && key_val != KEY_SECOND) |=> !unlocked_o);
  // R4
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && key_val == KEY_RELOCK) |=> !unlocked_o);
endmodule

// File: rtl/pwrseq_script_mem.sv
module pwrseq_script_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] host_raddr,
  output logic [DW-1:0] host_rdata,
  input  logic [AW-1:0] seq_raddr,
  output logic [DW-1:0] seq_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign host_rdata = mem[host_raddr];
  assign seq_rdata  = mem[seq_raddr];

  // R7
  mem_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/pwrseq_cfg_regs.sv
module pwrseq_cfg_regs
  import pwrseq_cfg_pkg::*;
#(
  parameter int N_SLOT = 4,
  parameter int N_GRP  = 3,
  parameter int AW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [7:0]           addr,
  input  logic [7:0]           wdata,
  output logic [AW-1:0]        mem_ptr_o,
  output logic [N_SLOT*8-1:0]  slot_o,
  output logic [N_GRP*8-1:0]   grp_o,
  output logic [7:0]           trans_o
);
  localparam int GRP_BASE = 4 + N_SLOT;
  localparam int TRANS_A  = GRP_BASE + N_GRP;

  // memory pointer
  logic [AW-1:0] ptr_q, ptr_nx;
  always_comb begin
    ptr_nx = ptr_q;
    if (we && addr == A_MEMPTR) ptr_nx = wdata[AW-1:0];
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nx;
  end
  assign mem_ptr_o = ptr_q;

  // start slots
  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    logic [7:0] q, nx;
    always_comb begin
      nx = q;
      if (we && addr == 8'(4 + i)) nx = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= SLOT_RST;
      else        q <= nx;
    end
    assign slot_o[i*8 +: 8] = q;
  end

  // group event registers
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic [7:0] q, nx;
    always_comb begin
      nx = q;
      if (we && addr == 8'(GRP_BASE + g)) nx = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nx;
    end
    assign grp_o[g*8 +: 8] = q;
  end

  // transition configuration
  logic [7:0] trans_q, trans_nx;
  always_comb begin
    trans_nx = trans_q;
    if (we && addr == 8'(TRANS_A)) trans_nx = wdata;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trans_q <= TRANS_RST;
    else        trans_q <= trans_nx;
  end
  assign trans_o = trans_q;

  // R9
  grp0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == 8'(GRP_BASE)) |=> $stable(grp_o[7:0]));
endmodule

// File: rtl/pwrseq_cfg_bank.sv
module pwrseq_cfg_bank
  import pwrseq_cfg_pkg::*;
#(
  parameter int N_SLOT = 4,
  parameter int N_GRP  = 3,
  parameter int MEM_AW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [7:0]           addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  input  logic [MEM_AW-1:0]    seq_raddr,
  output logic [7:0]           seq_rdata,
  output logic [N_SLOT*8-1:0]  slot_o,
  output logic [N_GRP*8-1:0]   grp_evt_o,
  output logic [7:0]           trans_cfg_o,
  output logic                 unlocked_o,
  output logic                 err_o
);
  localparam int GRP_BASE = 4 + N_SLOT;
  localparam int TRANS_A  = GRP_BASE + N_GRP;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  logic rst_s_n;
  assign rst_s_n = rst_sync[1];

  // decode
  logic key_we, stat_we, prot_hit, prot_we;
  assign key_we   = wr_en && (addr == A_KEY);
  assign stat_we  = wr_en && (addr == A_STATUS);
  assign prot_hit = (addr >= A_MEMPTR) && (addr <= 8'(TRANS_A));
  assign prot_we  = wr_en && prot_hit && unlocked_o;

  pwrseq_key_guard u_key (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .key_we     (key_we),
    .key_val    (wdata),
    .unlocked_o (unlocked_o)
  );

  logic [MEM_AW-1:0] mem_ptr;
  pwrseq_cfg_regs #(.N_SLOT(N_SLOT), .N_GRP(N_GRP), .AW(MEM_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .we        (prot_we),
    .addr      (addr),
    .wdata     (wdata),
    .mem_ptr_o (mem_ptr),
    .slot_o    (slot_o),
    .grp_o     (grp_evt_o),
    .trans_o   (trans_cfg_o)
  );

  logic [7:0] host_mem_rd;
  pwrseq_script_mem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .we         (prot_we && addr == A_MEMDATA),
    .waddr      (mem_ptr),
    .wdata      (wdata),
    .host_raddr (mem_ptr),
    .host_rdata (host_mem_rd),
    .seq_raddr  (seq_raddr),
    .seq_rdata  (seq_rdata)
  );

  // sticky error flag
  logic err_q, err_nx;
  always_comb begin
    err_nx = err_q;
    if (wr_en && prot_hit && !unlocked_o) err_nx = 1'b1;
    else if (stat_we && wdata[0])         err_nx = 1'b0;
  end
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) err_q <= 1'b0;
    else          err_q <= err_nx;
  end
  assign err_o = err_q;

  // host read mux
  always_comb begin
    rdata = '0;
    if (addr == A_KEY)          rdata = {7'd0, unlocked_o};
    else if (addr == A_STATUS)  rdata = {7'd0, err_q};
    else if (addr == A_MEMPTR)  rdata = 8'(mem_ptr);
    else if (addr == A_MEMDATA) rdata = host_mem_rd;
    else if (addr >= A_SLOT0 && addr < 8'(GRP_BASE))
      rdata = slot_o[(int'(addr) - 4)*8 +: 8];
    else if (addr >= 8'(GRP_BASE) && addr < 8'(TRANS_A))
      rdata = grp_evt_o[(int'(addr) - GRP_BASE)*8 +: 8];
    else if (addr == 8'(TRANS_A)) rdata = trans_cfg_o;
  end

  // R5
  locked_err_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && prot_hit && !unlocked_o) |=> err_o);
  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && prot_hit && !unlocked_o) |=>
      ($stable(slot_o) && $stable(grp_evt_o) && $stable(trans_cfg_o)));
  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (stat_we && wdata[0]) |=> !err_o);
endmodule

// File: tb/pwrseq_cfg_bank_bench.sv
module pwrseq_cfg_bank_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  addr, wdata, rdata, seq_raddr, seq_rdata;
  logic [31:0] slot_o;
  logic [23:0] grp_evt_o;
  logic [7:0]  trans_cfg_o;
  logic        unlocked_o, err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pwrseq_cfg_bank u_pwrseq_cfg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .seq_raddr(seq_raddr), .seq_rdata(seq_rdata),
    .slot_o(slot_o), .grp_evt_o(grp_evt_o), .trans_cfg_o(trans_cfg_o),
    .unlocked_o(unlocked_o), .err_o(err_o)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7) ^ 8'h5A);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic unlock();
    wr(8'h00, 8'hC0);
    wr(8'h00, 8'h0C);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    wr_en = 0; addr = 0; wdata = 0; seq_raddr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 unlocked", unlocked_o, 0);
    check("R1 err", err_o, 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'(4 + i), v); check("R1 slot", v, 8'h3F);
    end
    for (int g = 0; g < 3; g++) begin
      rd(8'(8 + g), v); check("R1 grp", v, 8'h00);
    end
    rd(8'h0B, v); check("R1 trans", v, 8'h02);
    rd(8'h02, v); check("R1 memptr", v, 8'h00);

    // R5 guarded writes while locked
    for (int a = 2; a <= 11; a++) begin
      wr(8'(a), 8'hA5);
      check("R5 err set", err_o, 1);
      wr(8'h01, 8'h01);
    end
    check("R5 slots held", slot_o, 32'h3F3F3F3F);
    check("R5 grp held", grp_evt_o, 24'h0);
    check("R5 trans held", trans_cfg_o, 8'h02);
    rd(8'h02, v); check("R5 memptr held", v, 8'h00);

    // R6 clear semantics
    wr(8'h05, 8'h11);
    wr(8'h01, 8'hFE);
    check("R6 write0 keeps", err_o, 1);
    rd(8'h01, v); check("R6 status read", v, 8'h01);
    wr(8'h01, 8'h01);
    check("R6 write1 clears", err_o, 0);

    // R2 / R3 sweep of second key value
    for (int k = 0; k < 256; k++) begin
      wr(8'h00, 8'hC0);
      wr(8'h00, 8'(k));
      check(k == 12 ? "R2 key pair" : "R3 wrong second", unlocked_o, (k == 12) ? 1 : 0);
      wr(8'h00, 8'h00);
    end
    // R3 broken orders
    wr(8'h00, 8'hC0); wr(8'h00, 8'h55); wr(8'h00, 8'h0C);
    check("R3 broken order", unlocked_o, 0);
    wr(8'h00, 8'h0C);
    check("R3 lone second", unlocked_o, 0);
    unlock();
    rd(8'h00, v); check("R2 key read", v, 8'h01);

    // R4 relock
    wr(8'h00, 8'h00);
    check("R4 relocked", unlocked_o, 0);
    wr(8'h06, 8'h77);
    check("R4 write refused", slot_o[23:16], 8'h3F);
    check("R4 err after relock", err_o, 1);
    wr(8'h01, 8'h01);

    // R7 full memory fill
    unlock();
    for (int a = 0; a < 256; a++) begin
      wr(8'h02, 8'(a));
      wr(8'h03, pat(a));
    end
    for (int a = 0; a < 256; a++) begin
      seq_raddr = 8'(a); #1;
      check("R7 seq port", seq_rdata, pat(a));
    end
    wr(8'h02, 8'h2B);
    rd(8'h03, v); check("R7 host read", v, pat(8'h2B));
    check("R7 no err", err_o, 0);

    // R8 no auto-increment
    wr(8'h02, 8'h40);
    wr(8'h03, 8'h11);
    wr(8'h03, 8'h22);
    rd(8'h02, v); check("R8 ptr unchanged", v, 8'h40);
    seq_raddr = 8'h40; #1; check("R8 last wins", seq_rdata, 8'h22);
    seq_raddr = 8'h41; #1; check("R8 neighbour", seq_rdata, pat(8'h41));

    // R9 read-modify-write on group registers
    for (int g = 0; g < 3; g++) begin
      wr(8'(8 + g), 8'(8'h08 | g));
      rd(8'(8 + g), v);
      check("R9 readback", v, 8'(8'h08 | g));
      wr(8'(8 + g), v | 8'h10);
    end
    check("R9 rmw", grp_evt_o, {8'h1A, 8'h19, 8'h18});

    // R10 transition config bit 1
    rd(8'h0B, v);
    wr(8'h0B, v & ~8'h02);
    check("R10 bit1 cleared", trans_cfg_o, 8'h00);
    wr(8'h0B, 8'hFD);
    check("R10 other bits", trans_cfg_o, 8'hFD);

    // R11 start slots
    for (int i = 0; i < 4; i++) wr(8'(4 + i), 8'(8'h2B + 4 * i));
    check("R11 slots", slot_o, {8'h37, 8'h33, 8'h2F, 8'h2B});
    rd(8'h07, v); check("R11 slot read", v, 8'h37);

    rd(8'h20, v); check("R1 unmapped read", v, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule